// File: doc/BRIEF.md
# Serial Host Port Status Flags

This block keeps the three status flags of a serial host port that runs either as an I2C port or as an SPI port, in master or slave role. The flags are a receive overrun error, a bus error and a busy indication. It also produces two control outputs for the transfer engine: a suspend request and a request to generate an I2C stop condition.

The unit watches the raw SCL and SDA lines to find I2C start and stop conditions. It also takes the slave-select state, the acknowledge result of each transmitted I2C byte, and the occupancy of the transmit holding register and the shift register. Further inputs are an end-of-word strobe, the overrun event from the receive FIFO, and the processor's read strobes for the status word and the receive FIFO. Every flag is registered. The flags are also gathered into a 24-bit status word at fixed bit positions.

Top module: `serhost_flags`

## Requirements
- R1: While `rst_n` is low, or during any cycle in which `soft_rst`, `port_rst` or `stop_state` is high, the next clock edge leaves `ovr_err`, `bus_err`, `busy`, `suspend_req` and `stop_req` all at 0.
- R2: A high `ovr_evt` sets `ovr_err` at the next edge. A `rxf_rd` that is not preceded by a qualifying status read leaves `ovr_err` set.
- R3: A `stat_rd` taken while `ovr_err` is 1 arms the clear, and the next `rxf_rd` then clears `ovr_err`. A new `ovr_evt` between those two reads cancels the arming. A `stat_rd` taken while `ovr_err` is 0 does not arm.
- R4: `bus_err` never becomes set while `is_master` is 0.
- R5: In I2C mode (`mode_spi`=0) as master, a cycle with `ack_done`=1 and `ack_ok`=0 sets `bus_err` and `suspend_req` at the next edge, together with a one-cycle `stop_req` pulse. If `ack_ok`=1, no error is raised.
- R6: In SPI mode as master, `ss_act`=1 sets `bus_err` at the next edge. `suspend_req` rises only on the edge after a cycle with `word_end`=1 and `bus_err` already set.
- R7: Once set, `bus_err` stays set whatever the other inputs do, until one of the clear sources of R1 occurs.
- R8: In I2C mode, an SDA fall while SCL is high sets `busy`, and an SDA rise while SCL is high clears it. Each takes effect 3 clock edges after the line change, because of the two-flop synchronizers and the edge detector.
- R9: In SPI slave role, `busy` equals `ss_act` as it was one edge earlier. The transmit and shift occupancy inputs have no effect in this role.
- R10: In SPI master role, `busy` is the OR of `tx_full` and `shift_full` as they were one edge earlier.
- R11: `status_word` bit 22 is `busy`, bit 21 is `bus_err`, bit 20 is `ovr_err`, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Software reset, synchronous clear |
| port_rst | input | 1 | Port-level individual reset, synchronous clear |
| stop_state | input | 1 | Device in stop state; holds the flags clear |
| mode_spi | input | 1 | 1 = SPI, 0 = I2C |
| is_master | input | 1 | 1 = port is bus master |
| scl_in | input | 1 | Raw I2C clock line |
| sda_in | input | 1 | Raw I2C data line |
| ss_act | input | 1 | Slave select asserted (active high) |
| ack_done | input | 1 | Strobe: an I2C byte transmit finished |
| ack_ok | input | 1 | Acknowledge was received for that byte |
| tx_full | input | 1 | Transmit holding register occupied |
| shift_full | input | 1 | Shift register occupied |
| word_end | input | 1 | Strobe: current SPI word finished shifting |
| ovr_evt | input | 1 | Receive FIFO overrun event |
| stat_rd | input | 1 | Processor reads the status word |
| rxf_rd | input | 1 | Processor reads the receive FIFO |
| ovr_err | output | 1 | Receive overrun flag |
| bus_err | output | 1 | Bus error flag |
| busy | output | 1 | Busy flag |
| suspend_req | output | 1 | Suspend request to the transfer engine |
| stop_req | output | 1 | One-cycle request to generate an I2C stop |
| status_word | output | 24 | Flags at bits 22, 21, 20 |

## Verification
A lost or stuck arming bit shows up at `ovr_err` within one edge of the next FIFO read. The flag either stays set after a correct status-then-FIFO read pair, or it drops after a FIFO read alone. A wrong I2C line history inside the synchronizers moves the `busy` edge away from the third clock after an SDA change, so every start and stop is checked at edges two and three. A bus error state that is wrongly cleared or never set appears at once on `bus_err` and `status_word`. A misplaced suspend shows as `suspend_req` rising before the end-of-word strobe.

// File: rtl/serhost_flags.sv
module serhost_flags #(
  parameter int SW       = 24,
  parameter int OVR_BIT  = 20,
  parameter int BERR_BIT = 21,
  parameter int BUSY_BIT = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          port_rst,
  input  logic          stop_state,
  input  logic          mode_spi,
  input  logic          is_master,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          ss_act,
  input  logic          ack_done,
  input  logic          ack_ok,
  input  logic          tx_full,
  input  logic          shift_full,
  input  logic          word_end,
  input  logic          ovr_evt,
  input  logic          stat_rd,
  input  logic          rxf_rd,
  output logic          ovr_err,
  output logic          bus_err,
  output logic          busy,
  output logic          suspend_req,
  output logic          stop_req,
  output logic [SW-1:0] status_word
);

  logic       clr;
  logic [1:0] scl_sy, sda_sy;
  logic       sda_prev;
  logic       start_det, stop_det;
  logic       i2c_bus, i2c_nxt;
  logic       spi_busy;
  logic       nack_err, ss_err;
  logic       armed;

  assign clr       = soft_rst | port_rst | stop_state;
  assign start_det = scl_sy[1] &  sda_prev & ~sda_sy[1];
  assign stop_det  = scl_sy[1] & ~sda_prev &  sda_sy[1];
  assign i2c_nxt   = start_det ? 1'b1 : (stop_det ? 1'b0 : i2c_bus);
  assign spi_busy  = is_master ? (tx_full | shift_full) : ss_act;
  assign nack_err  = ~mode_spi & is_master & ack_done & ~ack_ok;
  assign ss_err    =  mode_spi & is_master & ss_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy   <= 2'b11;
      sda_sy   <= 2'b11;
      sda_prev <= 1'b1;
    end else begin
      scl_sy   <= {scl_sy[0], scl_in};
      sda_sy   <= {sda_sy[0], sda_in};
      sda_prev <= sda_sy[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i2c_bus <= 1'b0;
      busy    <= 1'b0;
    end else if (clr) begin
      i2c_bus <= 1'b0;
      busy    <= 1'b0;
    end else begin
      i2c_bus <= i2c_nxt;
      busy    <= mode_spi ? spi_busy : i2c_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_err     <= 1'b0;
      suspend_req <= 1'b0;
      stop_req    <= 1'b0;
    end else if (clr) begin
      bus_err     <= 1'b0;
      suspend_req <= 1'b0;
      stop_req    <= 1'b0;
    end else begin
      stop_req <= nack_err;
      if (nack_err || ss_err)
        bus_err <= 1'b1;
      if (nack_err || (mode_spi && bus_err && word_end))
        suspend_req <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_err <= 1'b0;
      armed   <= 1'b0;
    end else if (clr) begin
      ovr_err <= 1'b0;
      armed   <= 1'b0;
    end else if (ovr_evt) begin
      ovr_err <= 1'b1;
      armed   <= 1'b0;
    end else if (rxf_rd) begin
      if (armed) ovr_err <= 1'b0;
      armed <= 1'b0;
    end else if (stat_rd && ovr_err) begin
      armed <= 1'b1;
    end
  end

  always_comb begin
    status_word           = '0;
    status_word[OVR_BIT]  = ovr_err;
    status_word[BERR_BIT] = bus_err;
    status_word[BUSY_BIT] = busy;
  end

endmodule

// File: rtl/serhost_flags_chk.sv
module serhost_flags_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic port_rst,
  input logic stop_state,
  input logic mode_spi,
  input logic is_master,
  input logic ack_done,
  input logic ack_ok,
  input logic word_end,
  input logic rxf_rd,
  input logic ovr_err,
  input logic bus_err,
  input logic busy,
  input logic suspend_req,
  input logic stop_req
);

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst || port_rst || stop_state) |=> (!ovr_err && !bus_err && !busy && !suspend_req && !stop_req)); // R1

  AST_OVR_FALL_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_err) |-> $past(rxf_rd || soft_rst || port_rst || stop_state)); // R3

  AST_BERR_MASTER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> $past(is_master)); // R4

  AST_STOP_ON_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req) |-> $past(!mode_spi && is_master && ack_done && !ack_ok)); // R5

  AST_SUSPEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspend_req) |-> $past((mode_spi && word_end && bus_err) ||
                                 (!mode_spi && is_master && ack_done && !ack_ok))); // R6

  AST_BERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !soft_rst && !port_rst && !stop_state) |=> bus_err); // R7

endmodule

bind serhost_flags serhost_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .port_rst(port_rst),
  .stop_state(stop_state), .mode_spi(mode_spi), .is_master(is_master),
  .ack_done(ack_done), .ack_ok(ack_ok), .word_end(word_end), .rxf_rd(rxf_rd),
  .ovr_err(ovr_err), .bus_err(bus_err), .busy(busy),
  .suspend_req(suspend_req), .stop_req(stop_req)
);

// File: tb/serhost_flags_tb.sv
module serhost_flags_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, port_rst = 0, stop_state = 0;
  logic mode_spi = 0, is_master = 0;
  logic scl_in = 1, sda_in = 1, ss_act = 0;
  logic ack_done = 0, ack_ok = 0, tx_full = 0, shift_full = 0, word_end = 0;
  logic ovr_evt = 0, stat_rd = 0, rxf_rd = 0;
  logic ovr_err, bus_err, busy, suspend_req, stop_req;
  logic [23:0] status_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  serhost_flags u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .port_rst(port_rst),
    .stop_state(stop_state), .mode_spi(mode_spi), .is_master(is_master),
    .scl_in(scl_in), .sda_in(sda_in), .ss_act(ss_act), .ack_done(ack_done),
    .ack_ok(ack_ok), .tx_full(tx_full), .shift_full(shift_full),
    .word_end(word_end), .ovr_evt(ovr_evt), .stat_rd(stat_rd), .rxf_rd(rxf_rd),
    .ovr_err(ovr_err), .bus_err(bus_err), .busy(busy),
    .suspend_req(suspend_req), .stop_req(stop_req), .status_word(status_word)
  );

  // {spi, master, ss, tx, shift, exp_busy, exp_berr}
  localparam int NV = 8;
  localparam logic [6:0] VEC [NV] = '{
    7'b11000_00, 7'b11010_10, 7'b11001_10, 7'b11011_10,
    7'b10100_10, 7'b10011_00, 7'b11100_01, 7'b11110_11
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [23:0] got, logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic pulse_port_rst();
    port_rst = 1; step(); port_rst = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) step();
    chk("R1 reset flags", {ovr_err, bus_err, busy, suspend_req, stop_req}, 0);
    rst_n = 1; step();
    chk("R1 after reset", status_word, 0);

    // R9 R10 R4 R6 table
    for (int i = 0; i < NV; i++) begin
      pulse_port_rst();
      {mode_spi, is_master, ss_act, tx_full, shift_full} = VEC[i][6:2];
      step();
      chk("R9/R10 busy", busy, VEC[i][1]);
      chk("R4/R6 bus_err", bus_err, VEC[i][0]);
    end

    // R6 suspend only at word end; R7 sticky
    ss_act = 0; tx_full = 0; shift_full = 0; pulse_port_rst();
    mode_spi = 1; is_master = 1; ss_act = 1; step();
    chk("R6 berr set", bus_err, 1);
    chk("R6 no early suspend", suspend_req, 0);
    ss_act = 0; repeat (4) step();
    chk("R6 still no suspend", suspend_req, 0);
    chk("R7 berr sticky", bus_err, 1);
    word_end = 1; step(); word_end = 0;
    chk("R6 suspend at word end", suspend_req, 1);
    chk("R11 berr bit21", status_word, 24'h200000);
    soft_rst = 1; step(); soft_rst = 0;
    chk("R1 soft_rst clears", {bus_err, suspend_req}, 0);

    // R5 I2C nack
    mode_spi = 0; is_master = 1; ack_done = 1; ack_ok = 1; step();
    chk("R5 ack ok no error", {bus_err, stop_req, suspend_req}, 0);
    ack_ok = 0; step(); ack_done = 0;
    chk("R5 nack error", {bus_err, stop_req, suspend_req}, 3'b111);
    step();
    chk("R5 stop pulse one cycle", {bus_err, stop_req}, 2'b10);
    stop_state = 1; step(); stop_state = 0;
    chk("R1 stop_state clears", bus_err, 0);
    is_master = 0; ack_done = 1; step(); ack_done = 0;
    chk("R4 slave nack ignored", {bus_err, stop_req}, 0);

    // R8 I2C start / stop
    pulse_port_rst();
    sda_in = 0; step(); step();
    chk("R8 busy not yet", busy, 0);
    step();
    chk("R8 busy on start", busy, 1);
    chk("R11 busy bit22", status_word, 24'h400000);
    sda_in = 1; step(); step();
    chk("R8 still busy", busy, 1);
    step();
    chk("R8 idle on stop", busy, 0);
    scl_in = 0; sda_in = 0; repeat (3) step();
    chk("R8 sda change with scl low ignored", busy, 0);
    scl_in = 1; sda_in = 1; repeat (3) step();

    // R2 R3 overrun
    ovr_evt = 1; step(); ovr_evt = 0;
    chk("R2 ovr set", ovr_err, 1);
    chk("R11 ovr bit20", status_word, 24'h100000);
    rxf_rd = 1; step(); rxf_rd = 0;
    chk("R2 fifo read alone keeps", ovr_err, 1);
    stat_rd = 1; step(); stat_rd = 0;
    chk("R3 status read keeps", ovr_err, 1);
    rxf_rd = 1; step(); rxf_rd = 0;
    chk("R3 two-step clears", ovr_err, 0);
    stat_rd = 1; step(); stat_rd = 0;
    ovr_evt = 1; step(); ovr_evt = 0;
    rxf_rd = 1; step(); rxf_rd = 0;
    chk("R3 read while clear does not arm", ovr_err, 1);
    stat_rd = 1; step(); stat_rd = 0;
    ovr_evt = 1; step(); ovr_evt = 0;
    rxf_rd = 1; step(); rxf_rd = 0;
    chk("R3 new overrun cancels arm", ovr_err, 1);
    port_rst = 1; step(); port_rst = 0;
    chk("R1 port_rst clears ovr", ovr_err, 0);
    ovr_evt = 1; step(); ovr_evt = 0;
    rst_n = 0; #1;
    chk("R1 async reset", ovr_err, 0);
    rst_n = 1; step();

    done = 1;
    finish_run();
  end

endmodule